// File: doc/BRIEF.md
# Dual-Lane Splittable Multiply-Accumulate Unit

This block is a one-cycle multiply-accumulate datapath built around two 16-bit signed multiplier lanes. It has three ways of working. In split mode each lane multiplies its own pair of 16-bit halves, and the two products are added together with the incoming accumulator into one 40-bit result. In joined mode the full 32-bit operands are multiplied together. The 64-bit product is cut down to 40 bits, either by truncation or by rounding, and is then accumulated. In pair mode the two lanes do not multiply. Each lane instead does its own 16-bit addition or subtraction.

A mode input selects three options: rounding of the joined product, saturation on overflow, and fractional (Q15/Q31) scaling. Every issued operation produces a registered result together with overflow, carry and sign flags. Both overflow flags also have a sticky copy. A sticky copy stays set until a clear strobe is applied.

Top module: `dmac_unit`

## Requirements
- R1: When `issue_i` is high at a rising clock edge, `res_o`, the four flags and `valid_o` reflect that operation from that edge on. `valid_o` is high for exactly the cycle after each issue. With `issue_i` low, `res_o` and the flags hold their values.
- R2: `op_i`=2'b00 (split) gives `acc_i` + a[15:0]·b[15:0] + a[31:16]·b[31:16`]`. All values are signed two's complement, and the sum is exact before any wrap or saturation to 40 bits. `mode_i[0]` has no effect in this mode.
- R3: `mode_i[2]` (fractional) doubles each product in split and joined modes. A 16-bit lane with both operands equal to 0x8000 yields 0x7FFFFFFF.
- R4: `op_i`=2'b01 (joined) forms the signed 64-bit product a·b. The product is shifted right arithmetically by 24 bits and then added to `acc_i`. In fractional mode, 0x80000000·0x80000000 gives a product of 2^63−1.
- R5: In joined mode, `mode_i[0]` (round) adds 2^23 to the product before the shift. This rounds half up on the discarded bits.
- R6: `op_i`=2'b10 adds and `op_i`=2'b11 subtracts, lane by lane. Lane 0 uses bits [15:0] and lane 1 uses bits [31:16]. Each lane's result is placed at the same bit position in `res_o`, and `res_o[39:32]`=0. In this mode `acc_i`, `mode_i[0]` and `mode_i[2]` are ignored.
- R7: In the multiply modes, `flag_v_o` is set when the exact sum lies outside the signed 32-bit range. `flag_gv_o` is set when the exact sum lies outside the signed 40-bit range. In pair mode, `flag_v_o` is set when either lane overflows 16 bits, and `flag_gv_o`=0.
- R8: In the multiply modes, `flag_c_o` is the carry out of bit 39 of the unsigned 40-bit addition of `acc_i` and the addend. In pair mode, it is the OR over the lanes of the unsigned carry (add) or borrow (subtract). `flag_ge_o` is set when the final result is non-negative; in pair mode this means both lanes are non-negative.
- R9: With `mode_i[1]` (saturate) set in the multiply modes and the 40-bit range exceeded, the result clamps to 0x7FFFFFFFFF or 0x8000000000, matching the sign of the exact sum. Without saturation it wraps.
- R10: With saturation set in pair mode, a lane that overflows clamps to 0x7FFF or 0x8000. Without saturation it wraps.
- R11: `sticky_v_o` and `sticky_gv_o` are set by an issued operation that raises the matching flag, and they hold until `sticky_clr_i`. When a clear and a setting operation fall in the same cycle, the set wins.
- R12: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | Start an operation this cycle |
| op_i | input | 2 | 00 split MAC, 01 joined MAC, 10 pair add, 11 pair subtract |
| mode_i | input | 3 | bit0 round, bit1 saturate, bit2 fractional |
| a_i | input | 32 | Operand A (two lanes or one word) |
| b_i | input | 32 | Operand B (two lanes or one word) |
| acc_i | input | 40 | Accumulator input |
| sticky_clr_i | input | 1 | Clear both sticky overflow bits |
| res_o | output | 40 | Registered result |
| valid_o | output | 1 | Result registered from previous cycle's issue |
| flag_v_o | output | 1 | 32-bit (or lane) overflow |
| flag_gv_o | output | 1 | 40-bit overflow |
| flag_c_o | output | 1 | Carry / borrow |
| flag_ge_o | output | 1 | Result non-negative |
| sticky_v_o | output | 1 | Sticky 32-bit overflow |
| sticky_gv_o | output | 1 | Sticky 40-bit overflow |

## Verification
The hardest case to reach from the ports is the joined fractional product 0x80000000·0x80000000 with rounding on. That single case is the only way a product alone, with no help from the accumulator, can go past the 40-bit range. It therefore exercises the wide addend path, the 40-bit overflow flag and clamping all at once. The stimulus issues this operand pair directly with a zero accumulator, once with and once without rounding and saturation. Separate vectors preload the accumulator at the 40-bit limits to drive wrap and clamp in both directions. A same-cycle clear plus overflowing issue tests the sticky priority.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {
    OP_MAC_SPLIT = 2'b00,
    OP_MAC_JOIN  = 2'b01,
    OP_ADD_PAIR  = 2'b10,
    OP_SUB_PAIR  = 2'b11
  } dmac_op_e;

  typedef struct packed {
    logic frac;
    logic sat;
    logic rnd;
  } dmac_mode_t;
endpackage

// File: rtl/dmac_lane_mul.sv
module dmac_lane_mul #(
  parameter int W = 16
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           frac_i,
  output logic [2*W-1:0] prod_o
);
  localparam int PW = 2 * W;
  localparam logic [W-1:0]  MIN_IN  = {1'b1, {(W-1){1'b0}}};
  localparam logic [PW-1:0] MAX_OUT = {1'b0, {(PW-1){1'b1}}};

  logic signed [PW-1:0] raw;
  logic                 both_min;

  assign raw      = $signed(a_i) * $signed(b_i);
  assign both_min = (a_i == MIN_IN) && (b_i == MIN_IN);

  always_comb begin
    if (!frac_i)       prod_o = raw;
    else if (both_min) prod_o = MAX_OUT;
    else               prod_o = raw <<< 1;
  end
endmodule

// File: rtl/dmac_wide_mul.sv
module dmac_wide_mul #(
  parameter int W     = 32,
  parameter int SHIFT = 24,
  parameter int OUT_W = 2 * W + 1 - SHIFT
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic             frac_i,
  input  logic             rnd_i,
  output logic [OUT_W-1:0] scaled_o
);
  localparam int PW = 2 * W;
  localparam logic [W-1:0]  MIN_IN  = {1'b1, {(W-1){1'b0}}};
  localparam logic [PW-1:0] MAX_OUT = {1'b0, {(PW-1){1'b1}}};

  logic signed [PW-1:0] raw;
  logic [PW-1:0]        prod;
  logic [PW:0]          ext;
  logic                 unused_lo;

  assign raw = $signed(a_i) * $signed(b_i);

  always_comb begin
    if (!frac_i)                                 prod = raw;
    else if ((a_i == MIN_IN) && (b_i == MIN_IN)) prod = MAX_OUT;
    else                                         prod = raw <<< 1;
  end

  // one extra sign bit keeps the rounded max product representable
  assign ext       = {prod[PW-1], prod} + ((PW+1)'(rnd_i) << (SHIFT - 1));
  assign scaled_o  = ext[PW:SHIFT];
  assign unused_lo = ^ext[SHIFT-1:0];
endmodule

// File: rtl/dmac_pair_alu.sv
module dmac_pair_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         sat_i,
  output logic [W-1:0] r_o,
  output logic         ovf_o,
  output logic         carry_o
);
  localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

  logic [W:0] s_ext;
  logic [W:0] u_ext;

  assign s_ext   = sub_i ? ({a_i[W-1], a_i} - {b_i[W-1], b_i})
                         : ({a_i[W-1], a_i} + {b_i[W-1], b_i});
  assign u_ext   = sub_i ? ({1'b0, a_i} - {1'b0, b_i})
                         : ({1'b0, a_i} + {1'b0, b_i});
  assign ovf_o   = s_ext[W] ^ s_ext[W-1];
  assign carry_o = u_ext[W];

  always_comb begin
    if (sat_i && ovf_o) r_o = s_ext[W] ? MIN_V : MAX_V;
    else                r_o = s_ext[W-1:0];
  end
endmodule

// File: rtl/dmac_unit.sv
module dmac_unit
  import dmac_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  issue_i,
  input  logic [1:0]            op_i,
  input  logic [2:0]            mode_i,
  input  logic [2*LANE_W-1:0]   a_i,
  input  logic [2*LANE_W-1:0]   b_i,
  input  logic [ACC_W-1:0]      acc_i,
  input  logic                  sticky_clr_i,
  output logic [ACC_W-1:0]      res_o,
  output logic                  valid_o,
  output logic                  flag_v_o,
  output logic                  flag_gv_o,
  output logic                  flag_c_o,
  output logic                  flag_ge_o,
  output logic                  sticky_v_o,
  output logic                  sticky_gv_o
);
  localparam int NLANE  = 2;
  localparam int PROD_W = 2 * LANE_W;
  localparam int WIDE_W = NLANE * LANE_W;
  localparam int SHIFT  = 2 * WIDE_W - ACC_W;
  localparam int ADD_W  = ACC_W + 1;
  localparam int SUM_W  = ACC_W + 2;
  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  dmac_mode_t mode;
  dmac_op_e   op;
  assign mode = dmac_mode_t'(mode_i);
  assign op   = dmac_op_e'(op_i);

  logic [PROD_W-1:0] prod   [NLANE];
  logic [LANE_W-1:0] pair_r [NLANE];
  logic [NLANE-1:0]  pair_ovf;
  logic [NLANE-1:0]  pair_cy;
  logic [NLANE-1:0]  pair_neg;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    dmac_lane_mul #(.W(LANE_W)) u_mul (
      .a_i    (a_i[g*LANE_W +: LANE_W]),
      .b_i    (b_i[g*LANE_W +: LANE_W]),
      .frac_i (mode.frac),
      .prod_o (prod[g])
    );
    dmac_pair_alu #(.W(LANE_W)) u_alu (
      .a_i     (a_i[g*LANE_W +: LANE_W]),
      .b_i     (b_i[g*LANE_W +: LANE_W]),
      .sub_i   (op == OP_SUB_PAIR),
      .sat_i   (mode.sat),
      .r_o     (pair_r[g]),
      .ovf_o   (pair_ovf[g]),
      .carry_o (pair_cy[g])
    );
    assign pair_neg[g] = pair_r[g][LANE_W-1];
  end

  logic [ADD_W-1:0] join_add;

  dmac_wide_mul #(.W(WIDE_W), .SHIFT(SHIFT), .OUT_W(ADD_W)) u_wide (
    .a_i      (a_i),
    .b_i      (b_i),
    .frac_i   (mode.frac),
    .rnd_i    (mode.rnd),
    .scaled_o (join_add)
  );

  // accumulate
  logic [ADD_W-1:0] split_add, addend;
  logic [SUM_W-1:0] full;
  logic             mac_v, mac_gv, mac_c;
  logic [ACC_W-1:0] mac_res, pair_res, nxt_res;
  logic             nxt_v, nxt_gv, nxt_c, nxt_ge;
  logic             is_pair;

  assign split_add = {{(ADD_W-PROD_W){prod[0][PROD_W-1]}}, prod[0]}
                   + {{(ADD_W-PROD_W){prod[1][PROD_W-1]}}, prod[1]};
  assign addend    = (op == OP_MAC_JOIN) ? join_add : split_add;
  assign full      = {{(SUM_W-ACC_W){acc_i[ACC_W-1]}}, acc_i}
                   + {{(SUM_W-ADD_W){addend[ADD_W-1]}}, addend};

  assign mac_v  = !((&full[SUM_W-1:WIDE_W-1]) || !(|full[SUM_W-1:WIDE_W-1]));
  assign mac_gv = !((&full[SUM_W-1:ACC_W-1])  || !(|full[SUM_W-1:ACC_W-1]));
  // carry out of the top accumulator bit, rebuilt from the sum bit
  assign mac_c  = (acc_i[ACC_W-1] & addend[ACC_W-1])
                | ((acc_i[ACC_W-1] | addend[ACC_W-1]) & ~full[ACC_W-1]);

  always_comb begin
    if (mode.sat && mac_gv) mac_res = full[SUM_W-1] ? ACC_MIN : ACC_MAX;
    else                    mac_res = full[ACC_W-1:0];
  end

  assign pair_res = {{(ACC_W-WIDE_W){1'b0}}, pair_r[1], pair_r[0]};
  assign is_pair  = (op == OP_ADD_PAIR) || (op == OP_SUB_PAIR);

  always_comb begin
    if (is_pair) begin
      nxt_res = pair_res;
      nxt_v   = |pair_ovf;
      nxt_gv  = 1'b0;
      nxt_c   = |pair_cy;
      nxt_ge  = ~(|pair_neg);
    end else begin
      nxt_res = mac_res;
      nxt_v   = mac_v;
      nxt_gv  = mac_gv;
      nxt_c   = mac_c;
      nxt_ge  = ~mac_res[ACC_W-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o     <= '0;
      valid_o   <= 1'b0;
      flag_v_o  <= 1'b0;
      flag_gv_o <= 1'b0;
      flag_c_o  <= 1'b0;
      flag_ge_o <= 1'b0;
    end else begin
      valid_o <= issue_i;
      if (issue_i) begin
        res_o     <= nxt_res;
        flag_v_o  <= nxt_v;
        flag_gv_o <= nxt_gv;
        flag_c_o  <= nxt_c;
        flag_ge_o <= nxt_ge;
      end
    end
  end

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_v_o  <= 1'b0;
      sticky_gv_o <= 1'b0;
    end else begin
      sticky_v_o  <= (sticky_v_o  & ~sticky_clr_i) | (issue_i & nxt_v);
      sticky_gv_o <= (sticky_gv_o & ~sticky_clr_i) | (issue_i & nxt_gv);
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |=> valid_o);
  // R1
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> $stable(res_o) && $stable(flag_v_o) && $stable(flag_gv_o));
  // R7
  gv_implies_v_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_gv_o |-> flag_v_o);
  // R11
  sticky_v_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sticky_v_o) |-> $past(sticky_clr_i));
  // R11
  sticky_gv_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && flag_gv_o) |-> sticky_gv_o);
  // R9
  sat_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(issue_i && mode_i[1] && !op_i[1]) && flag_gv_o)
      |-> (res_o == ACC_MAX || res_o == ACC_MIN));
  // R6
  pair_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(issue_i && op_i[1]) |-> (res_o[ACC_W-1:WIDE_W] == '0) && !flag_gv_o);
endmodule

// File: tb/sim_dmac_unit.sv
module sim_dmac_unit;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    logic [39:0] res;
    bit v, gv, c, ge, sv, sgv;
    string req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [2:0]  mode = 3'b000;
  logic [31:0] a = '0, b = '0;
  logic [39:0] acc = '0;
  logic        clr = 1'b0;
  logic [39:0] res;
  logic        valid, fv, fgv, fc, fge, sv, sgv;

  int n_chk = 0, n_fail = 0;
  bit m_sv = 0, m_sgv = 0;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dmac_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .op_i(op), .mode_i(mode),
    .a_i(a), .b_i(b), .acc_i(acc), .sticky_clr_i(clr),
    .res_o(res), .valid_o(valid), .flag_v_o(fv), .flag_gv_o(fgv),
    .flag_c_o(fc), .flag_ge_o(fge), .sticky_v_o(sv), .sticky_gv_o(sgv)
  );

  function automatic logic signed [79:0] lane_prod(logic [15:0] x, logic [15:0] y, bit frac);
    logic signed [79:0] sx, sy, p;
    sx = $signed(x); sy = $signed(y);
    p = sx * sy;
    if (frac) p = (x == 16'h8000 && y == 16'h8000) ? 80'sd2147483647 : p * 2;
    return p;
  endfunction

  function automatic void lane_pair(logic [15:0] x, logic [15:0] y, bit sub, bit sat,
                                    output logic [15:0] r, output bit ovf, output bit cy);
    int sx, sy, s, ux, uy;
    sx = $signed(x); sy = $signed(y); ux = x; uy = y;
    s   = sub ? sx - sy : sx + sy;
    ovf = (s > 32767) || (s < -32768);
    r   = (ovf && sat) ? ((s < 0) ? 16'h8000 : 16'h7FFF) : s[15:0];
    cy  = sub ? (ux < uy) : ((ux + uy) > 65535);
  endfunction

  function automatic item_t model(logic [1:0] o, logic [2:0] m, logic [31:0] x,
                                  logic [31:0] y, logic [39:0] ac);
    item_t it;
    logic signed [79:0] addend, full, accx, sx, sy, p, lim40;
    logic [40:0] u;
    bit rnd = m[0], sat = m[1], frac = m[2];
    lim40 = (80'sd1 <<< 39);
    if (o[1]) begin
      logic [15:0] r0, r1; bit o0, o1, c0, c1;
      lane_pair(x[15:0],  y[15:0],  o[0], sat, r0, o0, c0);
      lane_pair(x[31:16], y[31:16], o[0], sat, r1, o1, c1);
      it.res = {8'h00, r1, r0};
      it.v = o0 | o1; it.gv = 0; it.c = c0 | c1;
      it.ge = !r0[15] && !r1[15];
    end else begin
      if (o == 2'b00) begin
        addend = lane_prod(x[15:0], y[15:0], frac) + lane_prod(x[31:16], y[31:16], frac);
      end else begin
        sx = $signed(x); sy = $signed(y);
        p = sx * sy;
        if (frac) p = (x == 32'h8000_0000 && y == 32'h8000_0000) ? ((80'sd1 <<< 63) - 1) : p * 2;
        if (rnd) p = p + (80'sd1 <<< 23);
        addend = p >>> 24;
      end
      accx = $signed(ac);
      full = accx + addend;
      it.v  = (full > 80'sd2147483647) || (full < -80'sd2147483648);
      it.gv = (full > lim40 - 1) || (full < -lim40);
      u = {1'b0, ac} + {1'b0, addend[39:0]};
      it.c = u[40];
      it.res = (sat && it.gv) ? ((full < 0) ? 40'h80_0000_0000 : 40'h7F_FFFF_FFFF) : full[39:0];
      it.ge = !it.res[39];
    end
    return it;
  endfunction

  task automatic apply(logic [1:0] o, logic [2:0] m, logic [31:0] x, logic [31:0] y,
                       logic [39:0] ac, bit c, string req);
    item_t it;
    @(negedge clk);
    issue = 1; op = o; mode = m; a = x; b = y; acc = ac; clr = c;
    it = model(o, m, x, y, ac);
    m_sv  = (m_sv  & !c) | it.v;
    m_sgv = (m_sgv & !c) | it.gv;
    it.sv = m_sv; it.sgv = m_sgv; it.req = req;
    q.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      issue = 0; clr = 0;
    end
  endtask

  task automatic check(bit ok, string req, string what, logic [39:0] act, logic [39:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (q.size() == 0) check(0, "R1", "unexpected valid", 40'(valid), 40'd0);
      else begin
        item_t e;
        e = q.pop_front();
        check(res == e.res, e.req, "res", res, e.res);
        check({fv, fgv, fc, fge} == {e.v, e.gv, e.c, e.ge}, e.req, "flags v/gv/c/ge",
              40'({fv, fgv, fc, fge}), 40'({e.v, e.gv, e.c, e.ge}));
        check({sv, sgv} == {e.sv, e.sgv}, e.req, "sticky", 40'({sv, sgv}), 40'({e.sv, e.sgv}));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    // R12: reset state
    check({res, valid, fv, fgv, fc, fge, sv, sgv} == '0, "R12", "reset outputs",
          40'({valid, fv, fgv, fc, fge, sv, sgv}), 40'd0);
    @(negedge clk); rst_n = 1;
    idle(1);

    apply(2'b00, 3'b000, {16'd5, 16'd3}, {16'd6, 16'd4}, 40'd10, 0, "R2");
    apply(2'b00, 3'b000, {-16'sd2, 16'd7}, {16'd9, -16'sd3}, 40'd0, 0, "R2");
    apply(2'b00, 3'b001, {16'd5, 16'd3}, {16'd6, 16'd4}, 40'd10, 0, "R2 rnd ignored");
    apply(2'b00, 3'b100, 32'h8000_8000, 32'h8000_8000, 40'd0, 0, "R3");
    apply(2'b00, 3'b100, {16'h4000, 16'hC000}, {16'h2000, 16'h4000}, 40'd0, 0, "R3");
    apply(2'b01, 3'b000, 32'h0100_0000, 32'd3, 40'd1, 0, "R4");
    apply(2'b01, 3'b000, 32'h0080_0000, 32'd1, 40'd0, 0, "R5 trunc");
    apply(2'b01, 3'b001, 32'h0080_0000, 32'd1, 40'd0, 0, "R5 round");
    apply(2'b01, 3'b001, 32'hFF80_0000, 32'd1, 40'd0, 0, "R5 neg half");
    apply(2'b01, 3'b100, 32'h8000_0000, 32'h8000_0000, 40'd0, 0, "R4 frac");
    apply(2'b01, 3'b101, 32'h8000_0000, 32'h8000_0000, 40'd0, 0, "R9 wrap");
    apply(2'b01, 3'b111, 32'h8000_0000, 32'h8000_0000, 40'd0, 0, "R9 clamp");
    apply(2'b00, 3'b000, 32'd1, 32'd1, 40'h7F_FFFF_FFFF, 0, "R7 gv");
    apply(2'b00, 3'b010, 32'd1, 32'd1, 40'h7F_FFFF_FFFF, 0, "R9 pos");
    apply(2'b00, 3'b010, 32'h0000_FFFF, 32'd1, 40'h80_0000_0000, 0, "R9 neg");
    apply(2'b00, 3'b000, 32'd1, 32'd1, 40'hFF_FFFF_FFFF, 0, "R8 carry");
    apply(2'b00, 3'b000, 32'd0, 32'd0, 40'h00_8000_0000, 0, "R7 v");
    apply(2'b10, 3'b101, {16'h7FFF, 16'd100}, {16'd1, 16'd23}, 40'h12_3456_789A, 0, "R6");
    apply(2'b10, 3'b010, {16'h7FFF, 16'd100}, {16'd1, 16'd23}, 40'd0, 0, "R10");
    apply(2'b11, 3'b000, {16'h8000, 16'd5}, {16'd1, 16'd9}, 40'd0, 0, "R6 sub");
    apply(2'b11, 3'b010, {16'h8000, 16'd5}, {16'd1, 16'd9}, 40'd0, 0, "R10 sub");
    apply(2'b10, 3'b000, 32'hFFFF_FFFF, 32'h0001_0001, 40'd0, 0, "R8 pair");
    apply(2'b00, 3'b000, 32'd2, 32'd2, 40'd0, 0, "R11 hold");
    idle(1);
    // R11: clear-only cycle drops both sticky bits
    @(negedge clk); clr = 1; m_sv = 0; m_sgv = 0;
    @(negedge clk); clr = 0;
    check({sv, sgv} == 2'b00, "R11", "sticky after clear", 40'({sv, sgv}), 40'd0);
    // R1: idle holds the previous result
    check(res == 40'd4 && valid == 0, "R1", "hold when idle", res, 40'd4);
    apply(2'b00, 3'b000, 32'd1, 32'd1, 40'h7F_FFFF_FFFF, 1, "R11 set wins");
    apply(2'b00, 3'b000, 32'd0, 32'd0, 40'd0, 0, "R11 hold");

    for (int i = 0; i < 160; i++) begin
      logic [39:0] ac;
      ac = {$urandom(), $urandom()};
      apply(2'(i % 4), 3'($urandom()), $urandom(), $urandom(), ac, ($urandom() % 9) == 0,
            (i % 4 == 0) ? "R2 rand" : (i % 4 == 1) ? "R4 rand" : "R6 rand");
    end
    idle(3);
    check(q.size() == 0, "R1", "pending results", 40'(q.size()), 40'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule